// File: doc/BRIEF.md
# Frame and Multiframe Sync Generator

This block turns a SONET-family reference clock into two timing marks. One is an 8 kHz frame sync. The other is a 2 kHz multiframe sync that spans four frames. Both come from one frame counter, and a two-bit frame counter sits beside it. Their edges therefore always fall on the same input clock edge, and the multiframe mark only ever starts together with a frame mark.

A 3-bit rate code tells the block which of six input clock rates it runs from, between 12.96 and 77.76 MHz. One mode bit sets the shape of both outputs:

- **Square wave:** 50% duty cycle.
- **Pulse:** a high-going pulse whose length comes from a 4-bit width field.

A one-clock tick on the last clock of every frame lets neighbouring logic line up with the frame. The frame length is a multiple of the parameter `UNIT`. Its default of 162 gives the real 8 kHz divide ratios. A smaller `UNIT` shrinks every frame by the same factor for quick runs.

Top module: `frame_sync_gen`

## Requirements
- R1: The frame length N in input clocks is `UNIT` times a factor chosen by `rate_sel_i`. The factors are: code 0 gives 10, code 1 gives 15, code 2 gives 20, code 3 gives 30, code 4 gives 40 and code 5 gives 60. With the default `UNIT` of 162 this gives 1620, 2430, 3240, 4860, 6480 and 9720 clocks.
- R2: Rate codes 6 and 7 give the same frame length as code 0.
- R3: During reset and after its release, both counters are at zero and all three outputs are low. Clock k after release is frame position k mod N of frame k div N. `frame_sync_o` stays low during frame 0. `mframe_sync_o` stays low during frames 0 to 3.
- R4: `frame_tick_o` is high for exactly one clock per frame, at frame position N-1, and low at every other position.
- R5: With `pulse_mode_i` = 0 (square wave), `frame_sync_o` is high at frame positions 0 to N/2-1 and low at positions N/2 to N-1.
- R6: With `pulse_mode_i` = 1 (pulse), `frame_sync_o` is high at frame positions 0 to W-1, where W is the value of `pulse_width_i` (1 to 15).
- R7: A `pulse_width_i` value of 0 gives the same one-clock pulse as a value of 1.
- R8: The multiframe spans four frames, counted modulo 4 from frame 0. With `pulse_mode_i` = 0, `mframe_sync_o` is high through frames 0 and 1 of each multiframe (2N clocks) and low through frames 2 and 3.
- R9: With `pulse_mode_i` = 1, `mframe_sync_o` is high for the first W clocks of frame 0 of each multiframe, on the same clocks where `frame_sync_o` is high.
- R10: In square-wave mode the value of `pulse_width_i` has no effect on either sync output.
- R11: A change of `pulse_mode_i` or `pulse_width_i` shows at the outputs from the next clock on. The frame and multiframe counting goes on without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at the rate named by `rate_sel_i` |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel_i | input | 3 | Input clock rate code (R1, R2) |
| pulse_mode_i | input | 1 | 0: square-wave outputs, 1: pulse outputs |
| pulse_width_i | input | 4 | Pulse length in input clocks; 0 is taken as 1 |
| frame_sync_o | output | 1 | 8 kHz frame sync |
| mframe_sync_o | output | 1 | 2 kHz multiframe sync |
| frame_tick_o | output | 1 | One-clock mark on the last clock of each frame |

## Verification
A frame counter that wraps one count too early or too late moves `frame_tick_o` within the first frame after reset. It then drags every later sync edge further off, one clock per frame.

A wrong two-bit frame count is different. It stays hidden until the fourth frame boundary. At that point `mframe_sync_o` either rises in the wrong frame or does not rise in step with `frame_sync_o`.

A bad width or shape decode shows in the first armed frame, as a high time of the wrong length. The sweep covers every rate code, both shapes and the edge widths 0, 1 and 15, each over ten frames.

// File: rtl/frame_sync_pkg.sv
package frame_sync_pkg;

  // Output shape selected by the mode bit.
  typedef enum logic {
    SHAPE_SQUARE = 1'b0,
    SHAPE_PULSE  = 1'b1
  } shape_e;

  // Number of frames in one multiframe, and the width of the frame-in-multiframe counter.
  localparam int unsigned FRAMES_PER_MF = 4;
  localparam int unsigned MF_CNT_W      = 2;

  // Largest frame-length factor over all rate codes.
  localparam int unsigned MAX_FACTOR    = 60;

  // Frame length factor for a rate code; codes 6 and 7 fall back to code 0.
  function automatic int unsigned rate_factor(input logic [2:0] code);
    case (code)
      3'd1:    return 15;
      3'd2:    return 20;
      3'd3:    return 30;
      3'd4:    return 40;
      3'd5:    return 60;
      default: return 10;
    endcase
  endfunction

  // Pulse length actually used: a zero field is taken as one clock.
  function automatic logic [3:0] eff_width(input logic [3:0] field);
    return (field == 4'd0) ? 4'd1 : field;
  endfunction

endpackage

// File: rtl/fsg_rate_decode.sv
module fsg_rate_decode #(
  parameter int unsigned UNIT  = 162,
  parameter int unsigned CNT_W = 14
) (
  input  logic [2:0]       rate_sel_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] last_o,
  output logic [CNT_W-1:0] half_o
);
  import frame_sync_pkg::*;

  logic [31:0] period_full;

  always_comb begin
    period_full = UNIT * rate_factor(rate_sel_i);
    period_o    = period_full[CNT_W-1:0];
    last_o      = period_o - CNT_W'(1);
    half_o      = period_o >> 1;
  end

endmodule

// File: rtl/fsg_counter.sv
module fsg_counter #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned MF_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] fcnt_q,
  output logic [CNT_W-1:0] fcnt_n,
  output logic [MF_W-1:0]  mcnt_q,
  output logic [MF_W-1:0]  mcnt_n,
  output logic             armf_q,
  output logic             armf_n,
  output logic             armm_n,
  output logic             frame_wrap
);
  logic armm_q;
  logic mf_wrap;

  always_comb begin
    // A count at or beyond the last position wraps; this also covers a switch to a shorter frame.
    frame_wrap = (fcnt_q >= last_i);
    mf_wrap    = frame_wrap && (mcnt_q == {MF_W{1'b1}});
    fcnt_n     = frame_wrap ? '0 : fcnt_q + CNT_W'(1);
    mcnt_n     = frame_wrap ? mcnt_q + MF_W'(1) : mcnt_q;
    armf_n     = armf_q | frame_wrap;
    armm_n     = armm_q | mf_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_q <= '0;
      mcnt_q <= '0;
      armf_q <= 1'b0;
      armm_q <= 1'b0;
    end else begin
      fcnt_q <= fcnt_n;
      mcnt_q <= mcnt_n;
      armf_q <= armf_n;
      armm_q <= armm_n;
    end
  end

endmodule

// File: rtl/fsg_shaper.sv
module fsg_shaper #(
  parameter int unsigned POS_W = 16
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] half_i,
  input  logic [3:0]       width_i,
  input  logic             pulse_mode_i,
  input  logic             armed_i,
  output logic             level_o
);
  import frame_sync_pkg::*;

  shape_e shape;

  always_comb begin
    shape = shape_e'(pulse_mode_i);
    if (!armed_i) begin
      level_o = 1'b0;
    end else if (shape == SHAPE_PULSE) begin
      level_o = (pos_i < POS_W'(width_i));
    end else begin
      level_o = (pos_i < half_i);
    end
  end

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
  parameter int unsigned UNIT = 162
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rate_sel_i,
  input  logic       pulse_mode_i,
  input  logic [3:0] pulse_width_i,
  output logic       frame_sync_o,
  output logic       mframe_sync_o,
  output logic       frame_tick_o
);
  import frame_sync_pkg::*;

  localparam int unsigned MAX_DIV = UNIT * MAX_FACTOR;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);
  localparam int unsigned MF_W    = MF_CNT_W;
  localparam int unsigned POS_W   = CNT_W + MF_W;
  localparam int unsigned NCH     = 2;   // channel 0 = frame sync, channel 1 = multiframe sync

  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] half_cnt;
  logic [CNT_W-1:0] fcnt_q;
  logic [CNT_W-1:0] fcnt_n;
  logic [MF_W-1:0]  mcnt_q;
  logic [MF_W-1:0]  mcnt_n;
  logic             armf_q;
  logic             armf_n;
  logic             armm_n;
  logic             frame_wrap;
  logic [3:0]       width_eff;
  logic [POS_W-1:0] mf_offset;
  logic             tick_n;

  logic [POS_W-1:0] ch_pos   [NCH];
  logic [POS_W-1:0] ch_half  [NCH];
  logic             ch_armed [NCH];
  logic             ch_level [NCH];

  fsg_rate_decode #(.UNIT(UNIT), .CNT_W(CNT_W)) u_rate (
    .rate_sel_i (rate_sel_i),
    .period_o   (period),
    .last_o     (last_cnt),
    .half_o     (half_cnt)
  );

  fsg_counter #(.CNT_W(CNT_W), .MF_W(MF_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .last_i     (last_cnt),
    .fcnt_q     (fcnt_q),
    .fcnt_n     (fcnt_n),
    .mcnt_q     (mcnt_q),
    .mcnt_n     (mcnt_n),
    .armf_q     (armf_q),
    .armf_n     (armf_n),
    .armm_n     (armm_n),
    .frame_wrap (frame_wrap)
  );

  always_comb begin
    width_eff = eff_width(pulse_width_i);
    // Offset of the next frame inside the multiframe: mcnt_n * N, built from shifts.
    mf_offset = (mcnt_n[1] ? (POS_W'(period) << 1) : '0) +
                (mcnt_n[0] ?  POS_W'(period)       : '0);
    tick_n    = (fcnt_n == last_cnt);

    ch_pos[0]   = POS_W'(fcnt_n);
    ch_half[0]  = POS_W'(half_cnt);
    ch_armed[0] = armf_n;
    ch_pos[1]   = mf_offset + POS_W'(fcnt_n);
    ch_half[1]  = POS_W'(period) << 1;
    ch_armed[1] = armm_n;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_shape
    fsg_shaper #(.POS_W(POS_W)) u_shape (
      .pos_i        (ch_pos[ch]),
      .half_i       (ch_half[ch]),
      .width_i      (width_eff),
      .pulse_mode_i (pulse_mode_i),
      .armed_i      (ch_armed[ch]),
      .level_o      (ch_level[ch])
    );
  end

  // Outputs are registered from next-state values, so each one matches the counter state it is shown with.
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_sync_o  <= 1'b0;
      mframe_sync_o <= 1'b0;
      frame_tick_o  <= 1'b0;
    end else begin
      frame_sync_o  <= ch_level[0];
      mframe_sync_o <= ch_level[1];
      frame_tick_o  <= tick_n;
    end
  end

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       rate_sel_i,
  input logic             pulse_mode_i,
  input logic [3:0]       pulse_width_i,
  input logic             frame_sync_o,
  input logic             mframe_sync_o,
  input logic             frame_tick_o,
  input logic             frame_wrap,
  input logic [CNT_W-1:0] fcnt_q,
  input logic [1:0]       mcnt_q,
  input logic [CNT_W-1:0] last_cnt,
  input logic             armf_q
);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    $stable(rate_sel_i) |-> (fcnt_q <= last_cnt)); // R1

  AST_QUIET_BEFORE_ARM: assert property (@(posedge clk) disable iff (rst)
    !armf_q |-> (!frame_sync_o && !mframe_sync_o)); // R3

  AST_TICK_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    $stable(rate_sel_i) |-> (frame_tick_o == (fcnt_q == last_cnt))); // R4

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_tick_o |=> !frame_tick_o); // R4

  AST_MF_STEP: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |=> (mcnt_q == $past(mcnt_q) + 2'd1)); // R8

  AST_MF_RISE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ($rose(mframe_sync_o) && $stable(pulse_mode_i) && $stable(pulse_width_i) && $stable(rate_sel_i))
      |-> $rose(frame_sync_o)); // R9

  AST_MF_PULSE_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode_i && $stable(pulse_mode_i) && mframe_sync_o) |-> frame_sync_o); // R9

endmodule

bind frame_sync_gen fsg_checker #(.CNT_W(CNT_W)) u_fsg_checker (
  .clk           (clk),
  .rst           (rst),
  .rate_sel_i    (rate_sel_i),
  .pulse_mode_i  (pulse_mode_i),
  .pulse_width_i (pulse_width_i),
  .frame_sync_o  (frame_sync_o),
  .mframe_sync_o (mframe_sync_o),
  .frame_tick_o  (frame_tick_o),
  .frame_wrap    (frame_wrap),
  .fcnt_q        (fcnt_q),
  .mcnt_q        (mcnt_q),
  .last_cnt      (last_cnt),
  .armf_q        (armf_q)
);

// File: tb/frame_sync_gen_bench.sv
module frame_sync_gen_bench;

  localparam int unsigned UNIT     = 2;
  localparam int unsigned NFRAMES  = 10;
  localparam int unsigned WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rate_sel;
  logic       pmode;
  logic [3:0] pwidth;
  logic       fsync, msync, ftick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  frame_sync_gen #(.UNIT(UNIT)) u_frame_sync_gen (
    .clk           (clk),
    .rst           (rst),
    .rate_sel_i    (rate_sel),
    .pulse_mode_i  (pmode),
    .pulse_width_i (pwidth),
    .frame_sync_o  (fsync),
    .mframe_sync_o (msync),
    .frame_tick_o  (ftick)
  );

  always #5 clk = ~clk;

  // Frame length as the requirements state it (R1, R2).
  function automatic int frame_len(input int code);
    int f;
    if      (code == 1) f = 15;
    else if (code == 2) f = 20;
    else if (code == 3) f = 30;
    else if (code == 4) f = 40;
    else if (code == 5) f = 60;
    else                f = 10;
    return f * UNIT;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Compare all outputs against an arithmetic model at clock k after reset.
  task automatic check_at(input int k, input int n, input string force_tag);
    int  pos, frm, mfr, w;
    bit  e_tick, e_f, e_m;
    string tf, tm, tt;
    pos = k % n;
    frm = k / n;
    mfr = frm % 4;
    w   = (pwidth == 0) ? 1 : int'(pwidth);
    e_tick = (pos == n - 1);
    if (frm < 1)     e_f = 1'b0;
    else if (pmode)  e_f = (pos < w);
    else             e_f = (pos < n / 2);
    if (frm < 4)     e_m = 1'b0;
    else if (pmode)  e_m = (mfr == 0) && (pos < w);
    else             e_m = (mfr < 2);
    tt = (rate_sel < 6) ? "R1/R4" : "R2/R4";
    if (frm < 1)              tf = "R3";
    else if (!pmode)          tf = "R5/R10";
    else if (pwidth == 4'd0)  tf = "R7";
    else                      tf = "R6";
    if (frm < 4)      tm = "R3";
    else if (!pmode)  tm = "R8/R10";
    else              tm = "R9";
    if (force_tag != "") begin
      tf = force_tag;
      tm = force_tag;
    end
    chk(tt, $sformatf("tick k=%0d", k), ftick, e_tick);
    chk(tf, $sformatf("frame sync k=%0d", k), fsync, e_f);
    chk(tm, $sformatf("multiframe sync k=%0d", k), msync, e_m);
  endtask

  // Reset, then run one configuration; optionally switch to pulse mode, width 5, part way (R11).
  task automatic run_cfg(input logic [2:0] rate, input logic mode, input logic [3:0] w,
                         input bit do_switch);
    int    n, total, sw_at;
    string tag;
    @(negedge clk);
    rst      = 1'b1;
    rate_sel = rate;
    pmode    = mode;
    pwidth   = w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n     = frame_len(int'(rate));
    total = n * NFRAMES;
    sw_at = n * 5 + n / 4;
    tag   = "";
    // R3: all outputs low right after reset release.
    chk("R3", "reset tick", ftick, 1'b0);
    chk("R3", "reset frame sync", fsync, 1'b0);
    chk("R3", "reset multiframe sync", msync, 1'b0);
    for (int k = 1; k < total; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_at(k, n, tag);
      if (do_switch && k == sw_at) begin
        pmode  = 1'b1;
        pwidth = 4'd5;
        tag    = "R11";
      end
    end
  endtask

  initial begin
    rate_sel = 3'd0;
    pmode    = 1'b0;
    pwidth   = 4'd0;
    for (int r = 0; r < 8; r++) begin
      run_cfg(3'(r), 1'b0, 4'd0,  1'b0);
      run_cfg(3'(r), 1'b0, 4'd9,  1'b0);   // R10: width ignored in square mode
      run_cfg(3'(r), 1'b1, 4'd0,  1'b0);   // R7
      run_cfg(3'(r), 1'b1, 4'd1,  1'b0);   // R6
      run_cfg(3'(r), 1'b1, 4'd7,  1'b0);   // R6
      run_cfg(3'(r), 1'b1, 4'd15, 1'b0);   // R6
    end
    run_cfg(3'd1, 1'b0, 4'd0, 1'b1);       // R11
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule